// File: doc/BRIEF.md
# Multithread Event Timer with Interrupt Steering

This block is a per-core event timer shared by sixteen hardware threads. A free-running count register climbs by one each clock and is compared with a limit register. When the count equals the limit on a cycle where it would advance, the count returns to zero on the next cycle, so the timer keeps running periodically without being reprogrammed. If interrupts are enabled, that match event is sent to every hardware thread whose bit is set in a thread-select mask. The same event reaches all selected threads in the same cycle.

Software reaches the timer through a simple auxiliary register port with an address, a write enable, write data and combinational read data. To arm a one-shot, software writes the limit, then writes zero to the count, then writes the control register with the enable bit set. A control bit can pause counting while the core's halted input is high. Each thread's interrupt line is a sticky pending flag. Any write to the control register clears every flag.

Top module: `mttimer_top`

## Requirements
- R1: After reset the count, limit, control and mask registers all read zero and every thread interrupt line is low.
- R2: Register map: count at address 0x21, control at 0x22, limit at 0x23, thread mask at 0xFFFFF850. All four can be written and read back. Control keeps only bit 0 (interrupt enable) and bit 1 (count-only-when-not-halted); its other bits read zero. The mask keeps 16 bits, and bit n selects thread n. Any other address reads zero.
- R3: The count advances by one per clock. The exception is when control bit 1 is set and the halted input is high: then the count holds. When bit 1 is clear, the halted input has no effect.
- R4: When the count equals the limit on a cycle where it advances, the next count value is zero, and counting then resumes from zero with no reprogramming.
- R5: A match with control bit 0 set sets the pending line of every thread selected in the mask. The line is visible one clock after the cycle in which the count reads equal to the limit. Unselected threads stay low. After the count is written with zero at a clock edge, the lines rise exactly limit+1 clocks later.
- R6: A pending line stays high until the control register is written. Any control write clears all lines. If a match occurs in the same cycle as the control write, the new event wins and the lines are set.
- R7: With control bit 0 clear, no interrupt line rises, and the count keeps running.
- R8: With an all-zero mask and interrupts enabled, matches occur but no thread line is driven.
- R9: A write to the count register overrides that cycle's advance and suppresses any match in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| auxAddr | input | 32 | Register address |
| auxWe | input | 1 | Write enable for the addressed register |
| auxWrData | input | 32 | Write data |
| auxRdData | output | 32 | Combinational read data for auxAddr |
| cpuHalted | input | 1 | High while the core is halted |
| threadIrq | output | 16 | Sticky per-thread interrupt lines |

## Verification
A register write takes effect at the clock edge where auxWe is sampled, and a read returns the new value in that same half-cycle. The count therefore reads k at the k-th clock after it is written to zero. Interrupt lines are registered once more, so they rise at clock limit+1, one clock after the count reads equal to the limit. Each test drives its inputs on the falling edge and counts whole clocks from a known write. It checks the count and the lines on the falling edge just before each expected change and again just after it.

// File: rtl/mttimer_pkg.sv
package mttimer_pkg;
  localparam int CTRL_W  = 2;
  localparam int CTRL_IE = 0;
  localparam int CTRL_NH = 1;

  typedef struct packed {
    logic wrCount;
    logic wrLimit;
    logic wrCtrl;
    logic wrMask;
    logic advance;
    logic wrap;
  } tmrStrobeT;
endpackage

// File: rtl/mttimer_ctrl.sv
module mttimer_ctrl
  import mttimer_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int NUM_THREADS = 16,
  parameter logic [ADDR_W-1:0] ADDR_COUNT = 'h21,
  parameter logic [ADDR_W-1:0] ADDR_CTRL  = 'h22,
  parameter logic [ADDR_W-1:0] ADDR_LIMIT = 'h23,
  parameter logic [ADDR_W-1:0] ADDR_MASK  = 'hFFFFF850
) (
  input  logic [ADDR_W-1:0]      auxAddr,
  input  logic                   auxWe,
  input  logic                   cpuHalted,
  input  logic [CNT_W-1:0]       countQ,
  input  logic [CNT_W-1:0]       limitQ,
  input  logic [CTRL_W-1:0]      ctrlQ,
  input  logic [NUM_THREADS-1:0] maskQ,
  output tmrStrobeT              stb,
  output logic                   fire,
  output logic [DATA_W-1:0]      rdData
);
  logic selCount, selCtrl, selLimit, selMask;
  logic canCount, atLimit;

  always_comb begin
    selCount = (auxAddr == ADDR_COUNT);
    selCtrl  = (auxAddr == ADDR_CTRL);
    selLimit = (auxAddr == ADDR_LIMIT);
    selMask  = (auxAddr == ADDR_MASK);

    // halt qualifier only matters when the control bit asks for it
    canCount = !(ctrlQ[CTRL_NH] && cpuHalted);
    atLimit  = (countQ == limitQ);

    stb.wrCount = auxWe && selCount;
    stb.wrLimit = auxWe && selLimit;
    stb.wrCtrl  = auxWe && selCtrl;
    stb.wrMask  = auxWe && selMask;
    stb.advance = canCount;
    stb.wrap    = atLimit;

    // a software count write pre-empts this cycle's match
    fire = atLimit && canCount && !stb.wrCount && ctrlQ[CTRL_IE];

    rdData = '0;
    if (selCount)      rdData = DATA_W'(countQ);
    else if (selCtrl)  rdData = DATA_W'(ctrlQ);
    else if (selLimit) rdData = DATA_W'(limitQ);
    else if (selMask)  rdData = DATA_W'(maskQ);
  end
endmodule

// File: rtl/mttimer_datapath.sv
module mttimer_datapath
  import mttimer_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int NUM_THREADS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tmrStrobeT              stb,
  input  logic [DATA_W-1:0]      wrData,
  output logic [CNT_W-1:0]       countQ,
  output logic [CNT_W-1:0]       limitQ,
  output logic [CTRL_W-1:0]      ctrlQ,
  output logic [NUM_THREADS-1:0] maskQ
);
  logic [CNT_W-1:0] countNext;

  always_comb begin
    countNext = countQ;
    if (stb.wrCount)      countNext = wrData[CNT_W-1:0];
    else if (stb.advance) countNext = stb.wrap ? '0 : countQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      limitQ <= '0;
      ctrlQ  <= '0;
      maskQ  <= '0;
    end else begin
      countQ <= countNext;
      if (stb.wrLimit) limitQ <= wrData[CNT_W-1:0];
      if (stb.wrCtrl)  ctrlQ  <= wrData[CTRL_W-1:0];
      if (stb.wrMask)  maskQ  <= wrData[NUM_THREADS-1:0];
    end
  end
endmodule

// File: rtl/mttimer_fanout.sv
module mttimer_fanout #(
  parameter int NUM_THREADS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fire,
  input  logic                   clearAll,
  input  logic [NUM_THREADS-1:0] maskQ,
  output logic [NUM_THREADS-1:0] pendQ
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        pendQ[t] <= 1'b0;
      else if (fire && maskQ[t])
        pendQ[t] <= 1'b1;   // a fresh event outranks a clear
      else if (clearAll)
        pendQ[t] <= 1'b0;
    end
  end
endmodule

// File: rtl/mttimer_top.sv
module mttimer_top
  import mttimer_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int NUM_THREADS = 16,
  parameter logic [ADDR_W-1:0] ADDR_COUNT = 'h21,
  parameter logic [ADDR_W-1:0] ADDR_CTRL  = 'h22,
  parameter logic [ADDR_W-1:0] ADDR_LIMIT = 'h23,
  parameter logic [ADDR_W-1:0] ADDR_MASK  = 'hFFFFF850
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      auxAddr,
  input  logic                   auxWe,
  input  logic [DATA_W-1:0]      auxWrData,
  output logic [DATA_W-1:0]      auxRdData,
  input  logic                   cpuHalted,
  output logic [NUM_THREADS-1:0] threadIrq
);
  tmrStrobeT              stb;
  logic                   fire;
  logic [CNT_W-1:0]       countQ;
  logic [CNT_W-1:0]       limitQ;
  logic [CTRL_W-1:0]      ctrlQ;
  logic [NUM_THREADS-1:0] maskQ;

  mttimer_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_THREADS(NUM_THREADS),
    .ADDR_COUNT(ADDR_COUNT), .ADDR_CTRL(ADDR_CTRL),
    .ADDR_LIMIT(ADDR_LIMIT), .ADDR_MASK(ADDR_MASK)
  ) u_ctrl (
    .auxAddr(auxAddr), .auxWe(auxWe), .cpuHalted(cpuHalted),
    .countQ(countQ), .limitQ(limitQ), .ctrlQ(ctrlQ), .maskQ(maskQ),
    .stb(stb), .fire(fire), .rdData(auxRdData)
  );

  mttimer_datapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_THREADS(NUM_THREADS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(auxWrData),
    .countQ(countQ), .limitQ(limitQ), .ctrlQ(ctrlQ), .maskQ(maskQ)
  );

  mttimer_fanout #(.NUM_THREADS(NUM_THREADS)) u_fan (
    .clk(clk), .rstN(rstN), .fire(fire), .clearAll(stb.wrCtrl),
    .maskQ(maskQ), .pendQ(threadIrq)
  );
endmodule

// File: rtl/mttimer_checker.sv
module mttimer_checker #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int NUM_THREADS = 16,
  parameter logic [ADDR_W-1:0] ADDR_COUNT = 'h21,
  parameter logic [ADDR_W-1:0] ADDR_CTRL  = 'h22
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      auxAddr,
  input logic                   auxWe,
  input logic                   cpuHalted,
  input logic [CNT_W-1:0]       countQ,
  input logic [CNT_W-1:0]       limitQ,
  input logic [1:0]             ctrlQ,
  input logic [NUM_THREADS-1:0] maskQ,
  input logic [NUM_THREADS-1:0] threadIrq
);
  logic cntWr, ctlWr, mayAdvance, willMatch;
  assign cntWr      = auxWe && (auxAddr == ADDR_COUNT);
  assign ctlWr      = auxWe && (auxAddr == ADDR_CTRL);
  assign mayAdvance = !(ctrlQ[1] && cpuHalted);
  assign willMatch  = (countQ == limitQ) && mayAdvance && !cntWr && ctrlQ[0];

  // R3: halted with the qualifier set freezes the count
  p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[1] && cpuHalted && !cntWr) |=> $stable(countQ));

  // R4: an advancing match wraps to zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((countQ == limitQ) && mayAdvance && !cntWr) |=> (countQ == '0));

  // R5: newly raised lines are a subset of the mask
  p_rise_in_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((threadIrq & ~$past(threadIrq) & ~$past(maskQ)) == '0));

  // R6: lines stay up without a control write
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWr |=> ((threadIrq & $past(threadIrq)) == $past(threadIrq)));

  // R6: a control write with no match drops every line
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !willMatch) |=> (threadIrq == '0));

  // R7: disabled interrupts never raise a line
  p_no_rise_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[0] |=> ((threadIrq & ~$past(threadIrq)) == '0));
endmodule

bind mttimer_top mttimer_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_THREADS(NUM_THREADS),
  .ADDR_COUNT(ADDR_COUNT), .ADDR_CTRL(ADDR_CTRL)
) u_chk (
  .clk(clk), .rstN(rstN), .auxAddr(auxAddr), .auxWe(auxWe),
  .cpuHalted(cpuHalted), .countQ(countQ), .limitQ(limitQ),
  .ctrlQ(ctrlQ), .maskQ(maskQ), .threadIrq(threadIrq)
);

// File: tb/tb_mttimer_top.sv
`timescale 1ns/1ps
module tb_mttimer_top;
  localparam logic [31:0] A_CNT  = 32'h21;
  localparam logic [31:0] A_CTL  = 32'h22;
  localparam logic [31:0] A_LIM  = 32'h23;
  localparam logic [31:0] A_MASK = 32'hFFFFF850;
  localparam int L = 20;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] auxAddr;
  logic        auxWe;
  logic [31:0] auxWrData;
  logic [31:0] auxRdData;
  logic        cpuHalted;
  logic [15:0] threadIrq;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mttimer_top dut (
    .clk(clk), .rstN(rstN), .auxAddr(auxAddr), .auxWe(auxWe),
    .auxWrData(auxWrData), .auxRdData(auxRdData),
    .cpuHalted(cpuHalted), .threadIrq(threadIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks begin and end just after a falling edge
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    auxAddr = a; auxWe = 1'b1; auxWrData = d;
    @(negedge clk);
    auxWe = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    auxAddr = a;
    #0.5;
    d = auxRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_CTL, v);  chk("R1 ctrl", v, 0);
    rd(A_LIM, v);  chk("R1 limit", v, 0);
    rd(A_MASK, v); chk("R1 mask", v, 0);
    chk("R1 irq", 32'(threadIrq), 0);
  endtask

  task automatic testRegMap();
    logic [31:0] v;
    wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, v); chk("R2 ctrl bits", v, 32'h3);
    wr(A_CTL, 32'h0);
    wr(A_MASK, 32'hFFFF_1234); rd(A_MASK, v); chk("R2 mask bits", v, 32'h1234);
    wr(A_LIM, 32'h0000_ABCD); rd(A_LIM, v); chk("R2 limit", v, 32'hABCD);
    rd(32'h24, v); chk("R2 unmapped", v, 0);
    wr(A_CNT, 32'd100); rd(A_CNT, v); chk("R9 count write", v, 100);
  endtask

  task automatic testHalt();
    logic [31:0] v;
    wr(A_LIM, 32'd1000);
    wr(A_CTL, 32'h2);
    wr(A_CNT, 32'd10);
    cpuHalted = 1'b1;
    waitCyc(5); rd(A_CNT, v); chk("R3 held while halted", v, 10);
    cpuHalted = 1'b0;
    waitCyc(3); rd(A_CNT, v); chk("R3 resumes", v, 13);
    wr(A_CTL, 32'h0);
    cpuHalted = 1'b1;
    waitCyc(4); rd(A_CNT, v); chk("R3 halt ignored", v, 18);
    cpuHalted = 1'b0;
  endtask

  task automatic testArm();
    logic [31:0] v;
    wr(A_MASK, 32'h8421);
    wr(A_LIM, L);
    wr(A_CNT, 32'd0);
    wr(A_CTL, 32'h1);
    waitCyc(L - 1);
    rd(A_CNT, v); chk("R4 count at limit", v, L);
    chk("R5 no irq before expiry", 32'(threadIrq), 0);
    waitCyc(1);
    chk("R5 irq to masked threads", 32'(threadIrq), 32'h8421);
    rd(A_CNT, v); chk("R4 wrap to zero", v, 0);
  endtask

  task automatic testSticky();
    logic [31:0] v;
    waitCyc(5);
    chk("R6 irq sticky", 32'(threadIrq), 32'h8421);
    wr(A_CTL, 32'h1);
    chk("R6 cleared by ctrl write", 32'(threadIrq), 0);
    waitCyc(L - 6);
    rd(A_CNT, v); chk("R4 periodic reaches limit", v, L);
    chk("R6 still clear", 32'(threadIrq), 0);
    waitCyc(1);
    chk("R4 periodic fires again", 32'(threadIrq), 32'h8421);
    waitCyc(L);
    wr(A_CTL, 32'h1);
    chk("R6 match wins over clear", 32'(threadIrq), 32'h8421);
  endtask

  task automatic testDisable();
    logic [31:0] v;
    wr(A_CTL, 32'h0);
    chk("R7 cleared", 32'(threadIrq), 0);
    wr(A_CNT, 32'd0);
    waitCyc(3); rd(A_CNT, v); chk("R7 count runs", v, 3);
    waitCyc(L + 2);
    chk("R7 no irq when disabled", 32'(threadIrq), 0);
  endtask

  task automatic testZeroMask();
    logic [31:0] v;
    wr(A_MASK, 32'h0);
    wr(A_CNT, 32'd0);
    wr(A_CTL, 32'h1);
    waitCyc(L + 3);
    chk("R8 zero mask no irq", 32'(threadIrq), 0);
    rd(A_CNT, v); chk("R8 timer wrapped", v, 3);
  endtask

  task automatic testCountOverride();
    logic [31:0] v;
    wr(A_MASK, 32'hFFFF);
    wr(A_CTL, 32'h1);
    wr(A_CNT, L - 1);
    waitCyc(1);
    rd(A_CNT, v); chk("R9 at limit", v, L);
    wr(A_CNT, 32'd5);
    rd(A_CNT, v); chk("R9 write overrides", v, 5);
    chk("R9 match suppressed", 32'(threadIrq), 0);
    waitCyc(1);
    chk("R9 still no irq", 32'(threadIrq), 0);
    rd(A_CNT, v); chk("R9 counts on", v, 6);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rstN = 1'b0; auxAddr = '0; auxWe = 1'b0; auxWrData = '0; cpuHalted = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegMap();
    testHalt();
    testArm();
    testSticky();
    testDisable();
    testZeroMask();
    testCountOverride();
    summary();
  end
endmodule